// File: doc/BRIEF.md
# Flash Mass-Erase Launch Controller

This block sits on a small synchronous register bus and guards the start of a whole-array flash erase. Software opens a command by writing anything to an aligned address inside the array window. It then writes the erase command code to the command register. Finally it writes a 1 to the buffer-empty bit of the status register, and that write launches the erase. The controller checks each step. A step written out of order, a launch before the clock divider has been written, or a new sequence started while an error flag is still set raises the access-error flag. A launch while any region is protected raises the protection-violation flag and does not start the erase.

A down-counter stands in for the flash array. At launch the controller pulses an erase strobe, then holds the buffer-empty and command-complete flags low for a fixed number of cycles. When the counter runs out it raises both flags again and pulses a done output. The error flags clear when software writes 1s to them. Writing 0 to any flag, or writing to the command-complete bit, has no effect.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, the status register (offset 0x01) reads 0xC0, the divider register (offset 0x00) reads 0x00, and divLoaded, eraseStart and eraseDone are 0.
- R2: The first write to offset 0x00 after reset stores wdata[6:0] and sets bit 7 of that register and the divLoaded output. Any later write to offset 0x00 before the next reset is ignored.
- R3: Three writes start the erase, and eraseStart is 1 for exactly the one cycle after the third write. The three writes are: any data to an array address (address bit 7 = 1, bit 0 = 0), then 0x41 to offset 0x02, then a value with bit 7 set to offset 0x01.
- R4: Status bits 7 (buffer empty) and 6 (command complete) read 0 for exactly ERASE_CYCLES cycles after the launch edge. Both then return to 1, and eraseDone pulses for one cycle in the same cycle.
- R5: If protActive is 1 at the launch write, status bit 5 (protection violation) sets, eraseStart stays 0 and the sequence returns to idle.
- R6: A launch before the divider has been written sets status bit 4 (access error) and does not start the erase.
- R7: An out-of-order step sets bit 4 and returns the sequence to idle. Out-of-order steps are: a command write or a launch in idle, a launch or an array write right after the array write, a command code other than 0x41, a misaligned array write, and an array or command write after the command.
- R8: While bit 4 or bit 5 is set, an array write sets bit 4 and does not open a sequence, so a following full sequence starts no erase.
- R9: Writing 1 to bit 5 or bit 4 clears that flag. Writing 0 leaves every flag unchanged. Bit 6 ignores all bus writes.
- R10: During an erase, an array write, a command write or a launch write sets bit 4. It does not change when the erase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Bus address; MSB set selects the array window |
| busWdata | input | DATA_W | Bus write data |
| busRdata | output | DATA_W | Read data for busAddr (combinational) |
| protActive | input | 1 | Some array region is protected |
| divLoaded | output | 1 | Clock divider has been written since reset |
| eraseStart | output | 1 | One-cycle erase strobe to the array stub |
| eraseDone | output | 1 | One-cycle completion pulse |

## Verification
The second step is swept over all 256 command codes. Only 0x41 may launch, and each accepted code must run a full erase of the configured length, so a widened or mistyped code compare shows up. The first step is swept over every array-window address. This separates aligned from misaligned openings, which expose a wrong alignment mask. Directed orderings then cover a launch without the divider, a launch under protection, sequences with a flag left set, and bus writes during an erase. Between them they separate the access-error cause from the protection cause and check that erase timing is not disturbed.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_CMD  = 2'd2,
    SEQ_BUSY = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadDiv;
    logic loadCnt;
    logic decCnt;
  } dpCtrl_t;

  localparam logic [7:0] CMD_MASS_ERASE = 8'h41;
  localparam int REG_DIV  = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CMD  = 2;
  localparam int BIT_CBE  = 7;
  localparam int BIT_CCF  = 6;
  localparam int BIT_PV   = 5;
  localparam int BIT_ACC  = 4;
endpackage

// File: rtl/fec_control.sv
module fec_control
  import fec_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int ALIGN_BITS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              protActive,
  input  logic              divLoaded,
  input  logic              cntZero,
  output dpCtrl_t           dpCtrl,
  output logic              cbeFlag,
  output logic              ccfFlag,
  output logic              pviolFlag,
  output logic              accerrFlag,
  output logic              eraseStart,
  output logic              eraseDone
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  seqState_t state, nextState;
  logic wrArray, wrAligned, wrDiv, wrStat, wrCmd, launchBit;
  logic setAcc, setPv, startC, doneC;

  assign wrArray   = busWe && busAddr[ADDR_W-1];
  assign wrAligned = wrArray && ((busAddr & ALIGN_MASK) == '0);
  assign wrDiv     = busWe && !busAddr[ADDR_W-1] && (busAddr[ADDR_W-2:0] == (ADDR_W-1)'(REG_DIV));
  assign wrStat    = busWe && !busAddr[ADDR_W-1] && (busAddr[ADDR_W-2:0] == (ADDR_W-1)'(REG_STAT));
  assign wrCmd     = busWe && !busAddr[ADDR_W-1] && (busAddr[ADDR_W-2:0] == (ADDR_W-1)'(REG_CMD));
  assign launchBit = wrStat && busWdata[BIT_CBE];

  always_comb begin
    nextState      = state;
    setAcc         = 1'b0;
    setPv          = 1'b0;
    startC         = 1'b0;
    doneC          = 1'b0;
    dpCtrl         = '0;
    dpCtrl.loadDiv = wrDiv && !divLoaded;
    unique case (state)
      SEQ_IDLE: begin
        if (wrArray) begin
          if (!wrAligned || accerrFlag || pviolFlag) setAcc = 1'b1;
          else nextState = SEQ_ADDR;
        end else if (wrCmd || launchBit) begin
          setAcc = 1'b1;
        end
      end
      SEQ_ADDR: begin
        if (wrCmd) begin
          if (busWdata == DATA_W'(CMD_MASS_ERASE)) nextState = SEQ_CMD;
          else begin setAcc = 1'b1; nextState = SEQ_IDLE; end
        end else if (wrArray || launchBit) begin
          setAcc = 1'b1; nextState = SEQ_IDLE;
        end
      end
      SEQ_CMD: begin
        if (launchBit) begin
          nextState = SEQ_IDLE;
          if (!divLoaded) setAcc = 1'b1;
          else if (protActive) setPv = 1'b1;
          else begin
            startC         = 1'b1;
            dpCtrl.loadCnt = 1'b1;
            nextState      = SEQ_BUSY;
          end
        end else if (wrArray || wrCmd) begin
          setAcc = 1'b1; nextState = SEQ_IDLE;
        end
      end
      SEQ_BUSY: begin
        if (wrArray || wrCmd || launchBit) setAcc = 1'b1;
        if (cntZero) begin doneC = 1'b1; nextState = SEQ_IDLE; end
        else dpCtrl.decCnt = 1'b1;
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      cbeFlag    <= 1'b1;
      ccfFlag    <= 1'b1;
      pviolFlag  <= 1'b0;
      accerrFlag <= 1'b0;
      eraseStart <= 1'b0;
      eraseDone  <= 1'b0;
    end else begin
      state      <= nextState;
      eraseStart <= startC;
      eraseDone  <= doneC;
      if (startC) begin
        cbeFlag <= 1'b0;
        ccfFlag <= 1'b0;
      end else if (doneC) begin
        cbeFlag <= 1'b1;
        ccfFlag <= 1'b1;
      end
      if (setAcc) accerrFlag <= 1'b1;
      else if (wrStat && busWdata[BIT_ACC]) accerrFlag <= 1'b0;
      if (setPv) pviolFlag <= 1'b1;
      else if (wrStat && busWdata[BIT_PV]) pviolFlag <= 1'b0;
    end
  end

  // R4: an erase in progress keeps both ready flags low
  assert_busy_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_BUSY) |-> (!cbeFlag && !ccfFlag));
  // R3: the launch strobe lasts one cycle and marks an erase in progress
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (state == SEQ_BUSY) ##1 !eraseStart);
  // R4: completion follows an erase and restores the flags
  assert_done_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |-> (cbeFlag && ccfFlag && $past(state == SEQ_BUSY)));
  // R5: a new protection violation never comes with a started erase
  assert_pviol_no_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pviolFlag) |-> (!eraseStart && state == SEQ_IDLE));
endmodule

// File: rtl/fec_datapath.sv
module fec_datapath
  import fec_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 64,
  localparam int DIV_W       = DATA_W - 1,
  localparam int CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DIV_W-1:0]  divIn,
  input  logic [3:0]        statusBits,
  output logic              divLoaded,
  output logic              cntZero,
  output logic [DATA_W-1:0] busRdata
);
  logic [DIV_W-1:0]  divReg;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] divWord, statWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg    <= '0;
      divLoaded <= 1'b0;
      cnt       <= '0;
    end else begin
      if (dpCtrl.loadDiv) begin
        divReg    <= divIn;
        divLoaded <= 1'b1;
      end
      if (dpCtrl.loadCnt) cnt <= CNT_W'(ERASE_CYCLES - 1);
      else if (dpCtrl.decCnt) cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    divWord               = '0;
    divWord[DATA_W-1]     = divLoaded;
    divWord[DIV_W-1:0]    = divReg;
    statWord              = '0;
    statWord[BIT_CBE:BIT_ACC] = statusBits;
    busRdata              = '0;
    if (!busAddr[ADDR_W-1]) begin
      if (busAddr[ADDR_W-2:0] == (ADDR_W-1)'(REG_DIV))       busRdata = divWord;
      else if (busAddr[ADDR_W-2:0] == (ADDR_W-1)'(REG_STAT)) busRdata = statWord;
    end
  end

  // R2: once written, the divider stays loaded until reset
  assert_div_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    divLoaded |=> divLoaded);
  // R4: the duration counter is only reloaded while it is idle at zero
  assert_cnt_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.loadCnt |-> cntZero);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int ALIGN_BITS   = 1,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              protActive,
  output logic              divLoaded,
  output logic              eraseStart,
  output logic              eraseDone
);
  localparam int DIV_W = DATA_W - 1;

  dpCtrl_t dpCtrl;
  logic cntZero, cbeFlag, ccfFlag, pviolFlag, accerrFlag;

  fec_control #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_control (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .protActive(protActive), .divLoaded(divLoaded),
    .cntZero(cntZero), .dpCtrl(dpCtrl), .cbeFlag(cbeFlag), .ccfFlag(ccfFlag),
    .pviolFlag(pviolFlag), .accerrFlag(accerrFlag),
    .eraseStart(eraseStart), .eraseDone(eraseDone)
  );

  fec_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .busAddr(busAddr),
    .divIn(busWdata[DIV_W-1:0]),
    .statusBits({cbeFlag, ccfFlag, pviolFlag, accerrFlag}),
    .divLoaded(divLoaded), .cntZero(cntZero), .busRdata(busRdata)
  );
endmodule

// File: tb/flash_erase_ctrl_tb.sv
module flash_erase_ctrl_tb;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic protActive = 1'b0;
  logic divLoaded, eraseStart, eraseDone;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_erase_ctrl #(.ADDR_W(8), .DATA_W(8), .ALIGN_BITS(1), .ERASE_CYCLES(N)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .protActive(protActive), .divLoaded(divLoaded),
    .eraseStart(eraseStart), .eraseDone(eraseDone)
  );

  task automatic chk(input string req, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // entered at a falling edge; consumes exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    busAddr = a; #1; v = busRdata;
  endtask

  task automatic runSeq(input logic [7:0] arr, input logic [7:0] code, output logic started);
    wr(arr, 8'hA5);
    wr(8'h02, code);
    wr(8'h01, 8'h80);
    started = eraseStart;
  endtask

  task automatic waitDone(output int cnt);
    logic [7:0] s;
    cnt = 0;
    rd(8'h01, s);
    while (!s[7] && cnt < 50) begin
      cnt++;
      @(negedge clk);
      rd(8'h01, s);
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic st;
    int c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h01, v); chk("R1 status", v, 8'hC0);
    rd(8'h00, v); chk("R1 divider", v, 8'h00);
    chk("R1 divLoaded", divLoaded, 0);
    chk("R1 eraseStart", eraseStart, 0);
    chk("R1 eraseDone", eraseDone, 0);

    // R6 launch before divider written
    runSeq(8'h80, 8'h41, st);
    chk("R6 no start", st, 0);
    rd(8'h01, v); chk("R6 status", v, 8'hD0);
    wr(8'h01, 8'h30);
    rd(8'h01, v); chk("R9 clear", v, 8'hC0);

    // R2 divider load and lock
    wr(8'h00, 8'h13);
    rd(8'h00, v); chk("R2 divider", v, 8'h93);
    chk("R2 divLoaded", divLoaded, 1);
    wr(8'h00, 8'h05);
    rd(8'h00, v); chk("R2 locked", v, 8'h93);

    // R3/R4 legal erase
    runSeq(8'h80, 8'h41, st);
    chk("R3 start", st, 1);
    rd(8'h01, v); chk("R4 busy status", v, 8'h00);
    @(negedge clk);
    chk("R3 start one cycle", eraseStart, 0);
    waitDone(c);
    chk("R4 busy cycles", c + 1, N);
    chk("R4 done pulse", eraseDone, 1);
    rd(8'h01, v); chk("R4 status after", v, 8'hC0);
    @(negedge clk);
    chk("R4 done one cycle", eraseDone, 0);

    // R5 protection
    protActive = 1'b1;
    runSeq(8'h84, 8'h41, st);
    chk("R5 no start", st, 0);
    rd(8'h01, v); chk("R5 status", v, 8'hE0);
    protActive = 1'b0;
    // R8 sequence with a flag still set
    runSeq(8'h80, 8'h41, st);
    chk("R8 no start", st, 0);
    rd(8'h01, v); chk("R8 status", v, 8'hF0);
    // R9 selective clear, zero writes, bit 6
    wr(8'h01, 8'h00);
    rd(8'h01, v); chk("R9 zero write", v, 8'hF0);
    wr(8'h01, 8'h10);
    rd(8'h01, v); chk("R9 clear acc", v, 8'hE0);
    wr(8'h01, 8'h20);
    rd(8'h01, v); chk("R9 clear pv", v, 8'hC0);

    // R7 launch right after array write
    wr(8'h80, 8'h00);
    wr(8'h01, 8'h80);
    chk("R7 early launch", eraseStart, 0);
    rd(8'h01, v); chk("R7 early launch status", v, 8'hD0);
    wr(8'h01, 8'h30);
    // R7 array write after command
    wr(8'h80, 8'h00); wr(8'h02, 8'h41); wr(8'h82, 8'h00);
    wr(8'h01, 8'h80);
    chk("R7 array after cmd", eraseStart, 0);
    wr(8'h01, 8'h30);
    // R7 command write in idle
    wr(8'h02, 8'h41);
    rd(8'h01, v); chk("R7 cmd in idle", v, 8'hD0);
    wr(8'h01, 8'h30);

    // R10 bus activity during erase, R9 bit 6 write ignored
    runSeq(8'h80, 8'h41, st);
    chk("R10 start", st, 1);
    wr(8'h01, 8'h40);
    rd(8'h01, v); chk("R9 bit6 ignored", v, 8'h00);
    wr(8'h02, 8'h41);
    rd(8'h01, v); chk("R10 acc in busy", v, 8'h10);
    waitDone(c);
    chk("R10 timing kept", c + 2, N);
    chk("R10 done", eraseDone, 1);
    rd(8'h01, v); chk("R10 status after", v, 8'hD0);
    wr(8'h01, 8'h30);

    // R3/R7 sweep of all command codes
    for (int code = 0; code < 256; code++) begin
      runSeq(8'h80, 8'(code), st);
      chk("R3 R7 code sweep", st, (code == 8'h41) ? 1 : 0);
      if (st) begin
        waitDone(c);
        chk("R4 code sweep cycles", c, N);
        rd(8'h01, v); chk("R4 code sweep status", v, 8'hC0);
      end else begin
        rd(8'h01, v); chk("R7 code sweep status", v, 8'hD0);
        wr(8'h01, 8'h30);
      end
    end

    // R3/R7 sweep of array addresses
    for (int a = 128; a < 256; a++) begin
      runSeq(8'(a), 8'h41, st);
      chk("R3 R7 addr sweep", st, (a % 2 == 0) ? 1 : 0);
      if (st) waitDone(c);
      rd(8'h01, v); chk("R7 addr sweep status", v, (a % 2 == 0) ? 8'hC0 : 8'hD0);
      wr(8'h01, 8'h30);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule